// File: doc/BRIEF.md
# DMA Channel Arming and Completion Interrupt Controller

This block is the control half of a multi-channel DMA engine. For each channel it holds whether the channel is idle, armed or busy, starts an armed channel when the trigger source selected for it fires, and stops channels on request through a shared arm register that carries an abort bit. A small busy/done model stands in for the transfer datapath. The controller tells that model which channels are busy, and it pulses an abort line toward it when a running channel is cancelled.

Each channel has a trigger code. Code 0 means the channel waits for software, which writes the channel's bit in the request register. Code 1 chains the channel to the completion of the channel numbered one below it. Codes 2 to 13 pick one of twelve external event pulses. When a channel completes normally it disarms itself and sets its bit in the completion flag register, whatever its interrupt mask is. The CPU interrupt line is formed from the stored flags and the masks. Software clears a flag by writing 0 to its bit.

Top module: `dma_arm_ctrl`

## Requirements
- R1: After reset every channel is idle (not armed, not busy), no request is pending, all completion flags are 0, `cpu_irq` is 0 and `xfer_abort` is 0.
- R2: A write to address 0 with bit 7 = 0 arms each idle channel whose bit (bit i for channel i) is 1. Channels whose bit is 0 are left as they were, and a write to a busy channel does not change it. Reading address 0 returns the armed channels (armed or busy) in bits [4:0].
- R3: A write to address 0 with bit 7 = 1 disarms every channel whose bit is 1, whether it is armed or busy, and clears its pending request. In the cycle of that write `xfer_abort[i]` is 1 for each selected channel that is busy. Channels whose bit is 0 are not affected.
- R4: An abort never sets a completion flag and never raises `cpu_irq`. An abort takes priority over `xfer_done` in the same cycle.
- R5: With trigger code 0, writing 1 to bit i of address 1 latches a request for channel i only if the channel is armed and not busy. Address 1 reads back the pending requests. At the next clock edge the channel becomes busy and its request bit clears. A request written for a channel that is not armed is dropped.
- R6: With trigger code 1, channel i (i >= 1) becomes busy at the same clock edge at which channel i-1 completes, provided channel i is armed. With code 1, channel 0 has no trigger.
- R7: Trigger code c in the range 2 to 13 selects `ext_trig[c-2]`. A pulse on that input makes an armed, idle channel busy at the next edge. A pulse arriving while the channel is not armed, or on an input other than the selected one, is ignored. Codes 14 and 15 never trigger.
- R8: `xfer_done[i]` while channel i is busy completes the channel. The channel returns to idle and flag bit i (address 2) is set, regardless of `irq_mask[i]`. `xfer_done` on a channel that is not busy is ignored.
- R9: `cpu_irq` is 1 exactly when some stored flag has its mask bit set. A flag that is already set therefore raises `cpu_irq` as soon as its mask bit goes to 1.
- R10: Writing address 2 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A completion in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 arm/abort, 1 request, 2 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| trig_sel | input | 20 | Per-channel trigger code, channel i in bits [4i+3:4i] |
| irq_mask | input | 5 | Per-channel interrupt enable |
| ext_trig | input | 12 | External event pulses, selected by codes 2 to 13 |
| xfer_done | input | 5 | Per-channel completion pulse from the datapath model |
| ch_busy | output | 5 | Channel is transferring |
| xfer_abort | output | 5 | Running channel is being cancelled this cycle |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The start function is tried with each trigger kind in turn. A software request is sent both to an armed channel and to an unarmed one, which separates a latched request from a dropped one. External pulses go to the selected input, to a wrong input and to a channel with an out-of-range code, which shows the selection is exact. A three-channel completion chain checks that each channel starts at the edge where its predecessor completes. Abort writes that hit an armed channel, a busy channel, a busy channel with a simultaneous done, and leave a neighbour unselected tell the abort path apart from the completion path. Flag tests set a flag with its mask off and turn the mask on later, and they combine a clear with a completion in the same cycle.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_ARMED = 2'd1,
    CH_BUSY  = 2'd2
  } ch_state_e;

  localparam logic [1:0] ADDR_ARM  = 2'd0;
  localparam logic [1:0] ADDR_REQ  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  localparam int TRIG_SW    = 0;
  localparam int TRIG_CHAIN = 1;
  localparam int TRIG_EXT0  = 2;

endpackage

// File: rtl/dma_trig_mux.sv
module dma_trig_mux #(
  parameter int TW   = 4,
  parameter int NEXT = 12
) (
  input  logic [TW-1:0]   code,
  input  logic            sw_req,
  input  logic            chain_in,
  input  logic [NEXT-1:0] ext_trig,
  output logic            evt
);
  import dma_arm_pkg::*;

  logic [NEXT-1:0] ext_hit;

  genvar k;
  generate
    for (k = 0; k < NEXT; k++) begin : g_ext
      assign ext_hit[k] = (code == TW'(k + TRIG_EXT0)) && ext_trig[k];
    end
  endgenerate

  always_comb begin
    evt = |ext_hit;
    if (code == TW'(TRIG_SW))    evt = sw_req;
    if (code == TW'(TRIG_CHAIN)) evt = chain_in;
  end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic abort_sel,
  input  logic req_set,
  input  logic code_is_sw,
  input  logic evt,
  input  logic done,
  output logic armed,
  output logic busy,
  output logic pend,
  output logic complete,
  output logic abort_stop
);
  import dma_arm_pkg::*;

  ch_state_e state_q, state_d;
  logic      state_en;
  logic      pend_q, pend_d;
  logic      pend_en;

  // next-state: abort beats done, done beats arm
  always_comb begin
    state_d = state_q;
    case (state_q)
      CH_IDLE:  if (arm_set) state_d = CH_ARMED;
      CH_ARMED: begin
        if (abort_sel)  state_d = CH_IDLE;
        else if (evt)   state_d = CH_BUSY;
      end
      CH_BUSY: begin
        if (abort_sel)  state_d = CH_IDLE;
        else if (done)  state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end
  assign state_en = (state_d != state_q);

  always_comb begin
    pend_d = pend_q;
    if (state_d != CH_ARMED)
      pend_d = 1'b0;
    else if (req_set && code_is_sw && state_q == CH_ARMED)
      pend_d = 1'b1;
  end
  assign pend_en = (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign armed      = (state_q != CH_IDLE);
  assign busy       = (state_q == CH_BUSY);
  assign pend       = pend_q;
  assign complete   = busy && done && !abort_sel;
  assign abort_stop = busy && abort_sel;

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int NCH = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] complete,
  input  logic           clr_wr,
  input  logic [NCH-1:0] clr_keep,
  input  logic [NCH-1:0] irq_mask,
  output logic [NCH-1:0] flags,
  output logic           cpu_irq
);

  logic [NCH-1:0] flag_q, flag_d;
  logic [NCH-1:0] clr_bits;
  logic           flag_en;

  always_comb begin
    clr_bits = clr_wr ? ~clr_keep : '0;
    flag_d   = (flag_q & ~clr_bits) | complete;
  end
  assign flag_en = (flag_d != flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flags   = flag_q;
  assign cpu_irq = |(flag_q & irq_mask);

endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl #(
  parameter int NCH  = 5,
  parameter int DW   = 8,
  parameter int AW   = 2,
  parameter int TW   = 4,
  parameter int NEXT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH*TW-1:0] trig_sel,
  input  logic [NCH-1:0]    irq_mask,
  input  logic [NEXT-1:0]   ext_trig,
  input  logic [NCH-1:0]    xfer_done,
  output logic [NCH-1:0]    ch_busy,
  output logic [NCH-1:0]    xfer_abort,
  output logic              cpu_irq
);
  import dma_arm_pkg::*;

  localparam int ABORT_BIT = DW - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // register write decode
  logic           wr_arm, wr_req, wr_flag, abort_wr;
  logic [NCH-1:0] arm_set, abort_sel, req_set;

  always_comb begin
    wr_arm    = reg_wr && (reg_addr == AW'(ADDR_ARM));
    wr_req    = reg_wr && (reg_addr == AW'(ADDR_REQ));
    wr_flag   = reg_wr && (reg_addr == AW'(ADDR_FLAG));
    abort_wr  = wr_arm && reg_wdata[ABORT_BIT];
    arm_set   = (wr_arm && !abort_wr) ? reg_wdata[NCH-1:0] : '0;
    abort_sel = abort_wr ? reg_wdata[NCH-1:0] : '0;
    req_set   = wr_req ? reg_wdata[NCH-1:0] : '0;
  end

  // per-channel trigger selection and state
  logic [NCH-1:0] armed_v, busy_v, pend_v, complete_v, abort_v, evt_v, chain_v;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      if (i == 0) begin : g_head
        assign chain_v[i] = 1'b0;
      end else begin : g_link
        assign chain_v[i] = complete_v[i-1];
      end

      dma_trig_mux #(
        .TW   (TW),
        .NEXT (NEXT)
      ) u_mux (
        .code     (trig_sel[i*TW +: TW]),
        .sw_req   (pend_v[i]),
        .chain_in (chain_v[i]),
        .ext_trig (ext_trig),
        .evt      (evt_v[i])
      );

      dma_chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_core_n),
        .arm_set    (arm_set[i]),
        .abort_sel  (abort_sel[i]),
        .req_set    (req_set[i]),
        .code_is_sw (trig_sel[i*TW +: TW] == TW'(TRIG_SW)),
        .evt        (evt_v[i]),
        .done       (xfer_done[i]),
        .armed      (armed_v[i]),
        .busy       (busy_v[i]),
        .pend       (pend_v[i]),
        .complete   (complete_v[i]),
        .abort_stop (abort_v[i])
      );
    end
  endgenerate

  logic [NCH-1:0] flags_v;

  dma_irq_flags #(
    .NCH (NCH)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .complete (complete_v),
    .clr_wr   (wr_flag),
    .clr_keep (reg_wdata[NCH-1:0]),
    .irq_mask (irq_mask),
    .flags    (flags_v),
    .cpu_irq  (cpu_irq)
  );

  // read mux
  always_comb begin
    case (reg_addr)
      AW'(ADDR_ARM):  reg_rdata = DW'(armed_v);
      AW'(ADDR_REQ):  reg_rdata = DW'(pend_v);
      AW'(ADDR_FLAG): reg_rdata = DW'(flags_v);
      default:        reg_rdata = '0;
    endcase
  end

  assign ch_busy    = busy_v;
  assign xfer_abort = abort_v;

endmodule

// File: rtl/dma_arm_ctrl_chk.sv
module dma_arm_ctrl_chk #(
  parameter int NCH = 5,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [NCH-1:0] xfer_done,
  input logic [NCH-1:0] armed,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] irq_mask,
  input logic           cpu_irq
);

  logic           abort_w;
  logic [NCH-1:0] sel_w;
  logic [NCH-1:0] done_ok;

  assign abort_w = reg_wr && (reg_addr == AW'(0)) && reg_wdata[DW-1];
  assign sel_w   = abort_w ? reg_wdata[NCH-1:0] : '0;
  assign done_ok = xfer_done & busy & ~sel_w;

  assert_abort_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> ((armed & $past(sel_w)) == '0));

  assert_abort_spares_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_w && xfer_done == '0) |=> ((armed & ~$past(sel_w)) == ($past(armed) & ~$past(sel_w))));

  assert_abort_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> ((flags & $past(sel_w)) == ($past(flags) & $past(sel_w))));

  assert_pend_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~armed) == '0));

  assert_start_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy & ~$past(busy) & ~$past(armed)) == '0));

  assert_done_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok != '0) |=> ((flags & $past(done_ok)) == $past(done_ok)));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & irq_mask) == '0) |-> !cpu_irq);

endmodule

bind dma_arm_ctrl dma_arm_ctrl_chk #(
  .NCH (NCH),
  .DW  (DW),
  .AW  (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .xfer_done (xfer_done),
  .armed     (armed_v),
  .busy      (busy_v),
  .pend      (pend_v),
  .flags     (flags_v),
  .irq_mask  (irq_mask),
  .cpu_irq   (cpu_irq)
);

// File: tb/sim_dma_arm_ctrl.sv
`timescale 1ns/1ps
module sim_dma_arm_ctrl;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [19:0] trig_sel;
  logic [4:0]  irq_mask;
  logic [11:0] ext_trig;
  logic [4:0]  xfer_done;
  logic [4:0]  ch_busy;
  logic [4:0]  xfer_abort;
  logic        cpu_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  dma_arm_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .trig_sel   (trig_sel),
    .irq_mask   (irq_mask),
    .ext_trig   (ext_trig),
    .xfer_done  (xfer_done),
    .ch_busy    (ch_busy),
    .xfer_abort (xfer_abort),
    .cpu_irq    (cpu_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_code(input int ch, input logic [3:0] c);
    trig_sel[ch*4 +: 4] = c;
  endtask

  task automatic done_pulse(input logic [4:0] m);
    xfer_done = m;
    tick();
    xfer_done = '0;
  endtask

  task automatic cleanup();
    wr(2'd0, 8'h9F);
    wr(2'd2, 8'h00);
    irq_mask = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 arm readback", v, 8'h00);
    rd(2'd1, v); chk("R1 request readback", v, 8'h00);
    rd(2'd2, v); chk("R1 flags", v, 8'h00);
    chk("R1 busy", ch_busy, 0);
    chk("R1 irq", cpu_irq, 0);
    chk("R1 abort line", xfer_abort, 0);
  endtask

  task automatic t_arm();
    logic [7:0] v;
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R2 arm 0 and 2", v, 8'h05);
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R2 zero bits leave state", v, 8'h07);
    chk("R2 no start on arm", ch_busy, 0);
    cleanup();
    rd(2'd0, v); chk("R3 abort all disarms", v, 8'h00);
  endtask

  task automatic t_swreq();
    logic [7:0] v;
    set_code(1, 4'd0);
    set_code(3, 4'd0);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h02);
    rd(2'd1, v); chk("R5 request latched", v, 8'h02);
    chk("R5 not yet busy", ch_busy, 0);
    tick();
    chk("R5 busy after request", ch_busy, 5'h02);
    rd(2'd1, v); chk("R5 request self-clears", v, 8'h00);
    wr(2'd1, 8'h08);
    rd(2'd1, v); chk("R5 unarmed request dropped", v, 8'h00);
    tick();
    chk("R5 unarmed channel stays idle", ch_busy, 5'h02);
    wr(2'd0, 8'h02);
    chk("R2 arm write to busy keeps it busy", ch_busy, 5'h02);
    done_pulse(5'h02);
    rd(2'd2, v); chk("R8 flag after done", v, 8'h02);
    rd(2'd0, v); chk("R8 disarmed after done", v, 8'h00);
    wr(2'd2, 8'h00);
    done_pulse(5'h02);
    rd(2'd2, v); chk("R8 done on idle ignored", v, 8'h00);
    cleanup();
  endtask

  task automatic t_ext();
    logic [7:0] v;
    set_code(2, 4'd7);
    ext_trig = 12'h020;
    tick();
    ext_trig = '0;
    chk("R7 unarmed pulse ignored", ch_busy, 0);
    rd(2'd0, v); chk("R7 unarmed pulse leaves idle", v, 8'h00);
    wr(2'd0, 8'h04);
    ext_trig = 12'h010;
    tick();
    ext_trig = '0;
    chk("R7 wrong input ignored", ch_busy, 0);
    ext_trig = 12'h020;
    tick();
    ext_trig = '0;
    chk("R7 selected input starts", ch_busy, 5'h04);
    set_code(4, 4'd14);
    wr(2'd0, 8'h10);
    ext_trig = 12'hFFF;
    tick();
    ext_trig = '0;
    chk("R7 code 14 never triggers", ch_busy, 5'h04);
    cleanup();
  endtask

  task automatic t_flag_irq();
    logic [7:0] v;
    set_code(2, 4'd2);
    wr(2'd0, 8'h04);
    ext_trig = 12'h001;
    tick();
    ext_trig = '0;
    done_pulse(5'h04);
    rd(2'd2, v); chk("R8 flag set with mask off", v, 8'h04);
    chk("R9 masked flag no irq", cpu_irq, 0);
    irq_mask = 5'h04;
    #1 chk("R9 late mask fires", cpu_irq, 1);
    wr(2'd2, 8'h04);
    rd(2'd2, v); chk("R10 bit written 1 kept", v, 8'h04);
    wr(2'd2, 8'hFB);
    rd(2'd2, v); chk("R10 bit written 0 cleared", v, 8'h00);
    chk("R9 irq drops after clear", cpu_irq, 0);
    // completion and clear in one cycle
    set_code(0, 4'd0);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    tick();
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00; xfer_done = 5'h01;
    tick();
    reg_wr = 1'b0; xfer_done = '0;
    rd(2'd2, v); chk("R10 completion beats clear", v, 8'h01);
    cleanup();
  endtask

  task automatic t_chain();
    logic [7:0] v;
    set_code(0, 4'd0);
    set_code(1, 4'd1);
    set_code(2, 4'd1);
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h01);
    tick();
    chk("R6 head started", ch_busy, 5'h01);
    done_pulse(5'h01);
    chk("R6 ch1 starts on ch0 completion", ch_busy, 5'h02);
    done_pulse(5'h02);
    chk("R6 ch2 starts on ch1 completion", ch_busy, 5'h04);
    done_pulse(5'h04);
    chk("R6 chain drains", ch_busy, 0);
    rd(2'd2, v); chk("R6 three flags", v, 8'h07);
    wr(2'd2, 8'h00);
    set_code(0, 4'd1);
    set_code(4, 4'd0);
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h10);
    tick();
    done_pulse(5'h10);
    chk("R6 ch0 has no predecessor", ch_busy, 0);
    rd(2'd0, v); chk("R6 ch0 still armed", v, 8'h01);
    cleanup();
  endtask

  task automatic t_abort();
    logic [7:0] v;
    for (int c = 0; c < 4; c++) set_code(c, 4'd0);
    irq_mask = 5'h1F;
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h03);
    tick();
    chk("R3 setup busy", ch_busy, 5'h03);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h85;
    #1 chk("R3 abort pulse for busy channel", xfer_abort, 5'h01);
    tick();
    reg_wr = 1'b0;
    rd(2'd0, v); chk("R3 selected disarmed, others kept", v, 8'h0A);
    chk("R3 unselected busy untouched", ch_busy, 5'h02);
    rd(2'd2, v); chk("R4 abort sets no flag", v, 8'h00);
    chk("R4 abort raises no irq", cpu_irq, 0);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h82; xfer_done = 5'h02;
    tick();
    reg_wr = 1'b0; xfer_done = '0;
    rd(2'd2, v); chk("R4 abort beats done", v, 8'h00);
    chk("R4 no irq on abort with done", cpu_irq, 0);
    rd(2'd0, v); chk("R3 ch3 still armed", v, 8'h08);
    cleanup();
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    trig_sel = '0; irq_mask = '0; ext_trig = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_arm();
    t_swreq();
    t_ext();
    t_flag_irq();
    t_chain();
    t_abort();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule